// File: doc/BRIEF.md
# Battery Charge and Replacement Flag Register

This block holds the primary status byte of a battery monitor at register-bus address 01h. Two of its bits are flags that hardware keeps current from charge and discharge events. Bit 7 shows that a valid charge rate is present. Bit 6 shows that the monitor has been reset and no full charge or end-of-discharge point has been reached since. The remaining six bits are plain storage for software.

The host reads and writes the whole byte over a simple register bus. Read data is combinational from the address, and a read changes nothing. The charge-rate comparator, the available-charge counter and the learned-capacity compare are built elsewhere. This block receives their results as inputs.

The comparator input is a level, and the register reacts to its changes. A transition to above-threshold sets bit 7, and a transition to at-or-below clears it. Between transitions, software may overwrite bit 7. When a hardware event and a bus write touch the same flag bit in one cycle, the hardware event decides that bit.

Top module: `batt_flag_reg`

## Requirements
- R1: Reads at address 01h return the register; reads at any other address return 00h; writes at other addresses change nothing.
- R2: While the asynchronous power-on reset `rst_n` is low, the register is 40h (bit 7 = 0, bit 6 = 1, bits 5:0 = 0).
- R3: A serial reset command (`srst_cmd` high at a clock edge) makes the register 40h after that edge, overriding any write or event in the same cycle.
- R4: Bit 7 becomes 1 after the edge at which `rate_above` is first seen high following a cycle where it was low (a comparator low at reset counts as low), unless R5 clears it in the same cycle.
- R5: Bit 7 becomes 0 after an edge where `rate_above` is low having been high the cycle before, or where `dsg_seen` is high; discharge wins over a same-cycle rise.
- R6: Bit 6 becomes 0 after an edge where `chg_step` and `cnt_at_full` are both high.
- R7: Bit 6 becomes 0 after an edge where `chg_step` and `edv1_flag` are both high; `cnt_at_full` or `edv1_flag` without `chg_step` leaves it unchanged.
- R8: A write at 01h stores `bus_wdata[5:0]` into bits 5:0, which read back unchanged until the next write or reset.
- R9: A write at 01h loads bits 7 and 6 from `bus_wdata[7]` and `bus_wdata[6]` only when no hardware event (R4 to R7) acts on that bit in the same cycle; otherwise the event decides.
- R10: With no write, no reset, no discharge or charge-step strobe, and the comparator unchanged, the register keeps its value, however often it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| srst_cmd | input | 1 | Serial reset command strobe |
| rate_above | input | 1 | Comparator: charge-rate voltage above threshold |
| dsg_seen | input | 1 | Discharge activity strobe |
| chg_step | input | 1 | Valid charge increment strobe |
| cnt_at_full | input | 1 | Available-charge count equals learned full capacity |
| edv1_flag | input | 1 | First end-of-discharge flag |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |

## Verification
The assertions check the following on every cycle:
- the address decode of read data;
- the serial reset value;
- the clearing of bit 7 by discharge and of bit 6 by a qualified charge step;
- hardware winning over a write;
- the setting of bit 7 on a comparator rise;
- the stability of the byte when nothing acts on it.

The bench's behavioural model and its directed scenarios show the end-to-end sequences. These include write-then-event orderings, flags re-armed by software and then cleared again, an asynchronous reset in mid-run, and mixed event patterns over a long pseudo-random run.

// File: rtl/batt_flag_pkg.sv
package batt_flag_pkg;
    localparam int unsigned FLG_W    = 8;
    localparam int unsigned STORE_W  = FLG_W - 2;
    localparam int unsigned ADDR_W   = 7;

    typedef struct packed {
        logic               chgs;
        logic               brp;
        logic [STORE_W-1:0] store;
    } flag_reg_t;

    localparam flag_reg_t FLAG_RST = '{chgs: 1'b0, brp: 1'b1, store: '0};
endpackage

// File: rtl/batt_flag_decode.sv
module batt_flag_decode #(
    parameter int unsigned       AW       = 7,
    parameter logic [AW-1:0]     REG_ADDR = 'h01
) (
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    output logic          hit,
    output logic          wr_hit
);
    always_comb begin
        hit    = (bus_addr == REG_ADDR);
        wr_hit = hit && bus_we;
    end
endmodule

// File: rtl/batt_flag_chgs_evt.sv
module batt_flag_chgs_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_cmd,
    input  logic rate_above,
    input  logic dsg_seen,
    output logic set_evt,
    output logic clr_evt
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d  = srst_cmd ? 1'b0 : rate_above;
        clr_evt = dsg_seen || (prev_q && !rate_above);
        set_evt = !clr_evt && rate_above && !prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/batt_flag_brp_evt.sv
module batt_flag_brp_evt (
    input  logic chg_step,
    input  logic cnt_at_full,
    input  logic edv1_flag,
    output logic clr_evt
);
    always_comb begin
        clr_evt = chg_step && (cnt_at_full || edv1_flag);
    end
endmodule

// File: rtl/batt_flag_reg.sv
module batt_flag_reg
    import batt_flag_pkg::*;
#(
    parameter int unsigned          AW       = ADDR_W,
    parameter logic [AW-1:0]        REG_ADDR = 'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_cmd,
    input  logic             rate_above,
    input  logic             dsg_seen,
    input  logic             chg_step,
    input  logic             cnt_at_full,
    input  logic             edv1_flag,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [FLG_W-1:0] bus_wdata,
    output logic [FLG_W-1:0] bus_rdata
);
    flag_reg_t flags_d, flags_q, wr_val;
    logic hit, wr_hit;
    logic chgs_set, chgs_clr, brp_clr;

    batt_flag_decode #(.AW(AW), .REG_ADDR(REG_ADDR)) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .hit      (hit),
        .wr_hit   (wr_hit)
    );

    batt_flag_chgs_evt u_chgs (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_cmd   (srst_cmd),
        .rate_above (rate_above),
        .dsg_seen   (dsg_seen),
        .set_evt    (chgs_set),
        .clr_evt    (chgs_clr)
    );

    batt_flag_brp_evt u_brp (
        .chg_step    (chg_step),
        .cnt_at_full (cnt_at_full),
        .edv1_flag   (edv1_flag),
        .clr_evt     (brp_clr)
    );

    always_comb begin
        wr_val  = flag_reg_t'(bus_wdata);
        flags_d = flags_q;
        if (wr_hit) flags_d = wr_val;
        if (chgs_clr)      flags_d.chgs = 1'b0;
        else if (chgs_set) flags_d.chgs = 1'b1;
        if (brp_clr)       flags_d.brp  = 1'b0;
        if (srst_cmd)      flags_d = FLAG_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAG_RST;
        else        flags_q <= flags_d;
    end

    always_comb begin
        bus_rdata = hit ? flags_q : '0;
    end
endmodule

// File: rtl/batt_flag_reg_chk.sv
module batt_flag_reg_chk #(
    parameter int unsigned   AW       = 7,
    parameter logic [AW-1:0] REG_ADDR = 'h01
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srst_cmd,
    input logic          rate_above,
    input logic          dsg_seen,
    input logic          chg_step,
    input logic          cnt_at_full,
    input logic          edv1_flag,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic [7:0]    flags_q
);
    p_addr_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

    p_srst_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        srst_cmd |=> (flags_q == 8'h40));

    p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_cmd && !dsg_seen && $rose(rate_above)) |=> flags_q[7]);

    p_dsg_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsg_seen && !srst_cmd) |=> !flags_q[7]);

    p_full_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_step && cnt_at_full && !srst_cmd) |=> !flags_q[6]);

    p_edv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_step && edv1_flag && !srst_cmd) |=> !flags_q[6]);

    p_store_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && !srst_cmd) |=> (flags_q[5:0] == $past(bus_wdata[5:0])));

    p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR && bus_wdata[7] && dsg_seen && !srst_cmd) |=> !flags_q[7]);

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_cmd && !bus_we && !dsg_seen && !chg_step && !rate_above && !$past(rate_above))
        |=> $stable(flags_q));
endmodule

bind batt_flag_reg batt_flag_reg_chk #(.AW(AW), .REG_ADDR(REG_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst_cmd    (srst_cmd),
    .rate_above  (rate_above),
    .dsg_seen    (dsg_seen),
    .chg_step    (chg_step),
    .cnt_at_full (cnt_at_full),
    .edv1_flag   (edv1_flag),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .flags_q     (flags_q)
);

// File: tb/batt_flag_reg_tb.sv
`timescale 1ns/1ps
module batt_flag_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n, srst_cmd, rate_above, dsg_seen, chg_step, cnt_at_full, edv1_flag, bus_we;
    logic [6:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_chgs, m_brp, m_store, m_prev;

    always #4 clk = ~clk;

    batt_flag_reg u_dut (
        .clk(clk), .rst_n(rst_n), .srst_cmd(srst_cmd), .rate_above(rate_above),
        .dsg_seen(dsg_seen), .chg_step(chg_step), .cnt_at_full(cnt_at_full),
        .edv1_flag(edv1_flag), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic model_reset();
        m_chgs = 0; m_brp = 1; m_store = 0; m_prev = 0;
    endtask

    task automatic compare(input string tag);
        logic [7:0] exp;
        exp = (bus_addr == 7'h01) ? {m_chgs[0], m_brp[0], m_store[5:0]} : 8'h00;
        vectors++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected=%02h at %0t", tag, bus_rdata, exp, $time);
        end
    endtask

    task automatic quiet();
        srst_cmd = 0; dsg_seen = 0; chg_step = 0; cnt_at_full = 0;
        edv1_flag = 0; bus_we = 0; bus_wdata = 8'h00; bus_addr = 7'h01;
    endtask

    // one clock: compute expected next state from the inputs now applied,
    // let the edge pass, then compare at the falling edge
    task automatic step(input string tag);
        int n_chgs, n_brp, n_store;
        bit wr, rise, fall;
        wr   = bus_we && (bus_addr == 7'h01);
        rise = rate_above && (m_prev == 0);
        fall = !rate_above && (m_prev == 1);
        n_chgs = m_chgs; n_brp = m_brp; n_store = m_store;
        if (wr) begin
            n_chgs = bus_wdata[7]; n_brp = bus_wdata[6]; n_store = bus_wdata[5:0];
        end
        if (dsg_seen || fall) n_chgs = 0;
        else if (rise)        n_chgs = 1;
        if (chg_step && (cnt_at_full || edv1_flag)) n_brp = 0;
        @(posedge clk);
        @(negedge clk);
        if (srst_cmd) model_reset();
        else begin
            m_chgs = n_chgs; m_brp = n_brp; m_store = n_store; m_prev = rate_above;
        end
        compare(tag);
    endtask

    task automatic write(input logic [7:0] d, input string tag);
        bus_we = 1; bus_wdata = d; bus_addr = 7'h01;
        step(tag);
        quiet();
    endtask

    initial begin
        rst_n = 0; rate_above = 0;
        quiet();
        model_reset();
        repeat (2) @(negedge clk);
        compare("R2");
        rst_n = 1;
        step("R10");

        // storage bits and whole-byte write
        write(8'h2A, "R8");
        step("R10"); step("R10");
        write(8'hC0, "R9");
        write(8'h15, "R8");

        // serial reset, alone and against a write
        write(8'hFF, "R8");
        srst_cmd = 1; step("R3"); quiet();
        write(8'h3F, "R8");
        srst_cmd = 1; bus_we = 1; bus_wdata = 8'h8C; step("R3"); quiet();

        // charge-status flag
        rate_above = 1; step("R4"); step("R10");
        rate_above = 0; step("R5"); step("R10");
        rate_above = 1; dsg_seen = 1; step("R5"); quiet();
        step("R5");
        write(8'h80, "R9");
        dsg_seen = 1; step("R5"); quiet();
        bus_we = 1; bus_wdata = 8'h80; dsg_seen = 1; step("R9"); quiet();
        rate_above = 0; step("R5");
        rate_above = 1; bus_we = 1; bus_wdata = 8'h00; step("R9"); quiet();

        // battery-replaced flag
        write(8'h40, "R9");
        cnt_at_full = 1; step("R7"); quiet();
        edv1_flag = 1; step("R7"); quiet();
        chg_step = 1; step("R7"); quiet();
        chg_step = 1; cnt_at_full = 1; step("R6"); quiet();
        write(8'h40, "R9");
        chg_step = 1; edv1_flag = 1; step("R7"); quiet();
        bus_we = 1; bus_wdata = 8'h40; chg_step = 1; cnt_at_full = 1; step("R9"); quiet();
        srst_cmd = 1; step("R3"); quiet();

        // address decode
        bus_addr = 7'h02; bus_we = 1; bus_wdata = 8'hFF; step("R1");
        bus_we = 0; step("R1");
        bus_addr = 7'h7F; step("R1");
        bus_addr = 7'h01; step("R1");

        // mixed pseudo-random run
        begin
            logic [15:0] lfsr;
            lfsr = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                rate_above  = lfsr[0] ^ lfsr[5];
                dsg_seen    = (lfsr[3:1] == 3'b000);
                chg_step    = lfsr[4];
                cnt_at_full = lfsr[6] & lfsr[7];
                edv1_flag   = lfsr[8] & lfsr[9];
                bus_we      = lfsr[10] & lfsr[11];
                bus_wdata   = lfsr[15:8] ^ lfsr[7:0];
                bus_addr    = lfsr[12] & lfsr[13] ? 7'h03 : 7'h01;
                srst_cmd    = (lfsr[15:11] == 5'b11111);
                step("R9");
            end
            quiet();
        end

        // asynchronous power-on reset mid-run
        write(8'hBF, "R8");
        #1 rst_n = 0; #1;
        model_reset();
        compare("R2");
        @(negedge clk); rst_n = 1;
        rate_above = 0;
        step("R2");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule